// File: doc/BRIEF.md
# Control Word Register Bank

This block keeps a small set of 10-bit configuration registers for a converter core. A host sends 16-bit control words as parallel values with a one-cycle valid strobe. Each word either writes a data field into a register or asks for a register's contents. Read results come back one clock later on a parallel output, together with a valid flag. The current contents of every register are also driven out as a flat vector, so the rest of the chip can use them directly.

The block also runs the power-on sequence. An active-low reset loads every register with its default value. After reset is released, the block stays busy for a fixed number of clock cycles, and it drops any control word that arrives in that time. On the last cycle of the busy window it samples the level of a data input pin, which selects master or slave operation. It holds that choice until the next reset.

Top module: `ctlword_regbank`

## Requirements
- R1: While rst_n is low, and after every reset, cfg_o holds the default of each register i in bits [10*i+9:10*i]. The default of register i is (0x0A5*i + 0x011) mod 1024.
- R2: A word is accepted when word_valid_i is high and busy_o is low. Bit 15 is the direction (1 = write), bits 14:10 are the address and bits 9:0 are the data. An accepted write to a writable address below 7 replaces only that register, and the new value shows on cfg_o after the next rising edge.
- R3: An accepted word with bit 15 = 0 is a read. One clock later it raises rd_valid_o for exactly one cycle and puts the addressed register on rd_data_o. The data field of a read changes no register.
- R4: rd_valid_o stays low after accepted writes and after idle cycles, and rd_data_o is zero whenever rd_valid_o is low.
- R5: Register 5 is read-only. Writes to it leave cfg_o unchanged, and reads of it always return its default.
- R6: A write to an address of 7 or above changes no register. A read of such an address returns zero with rd_valid_o high.
- R7: busy_o is high while rst_n is low. It falls at the 3074th rising edge after rst_n goes high: 2 edges of reset synchronization followed by a 3072-cycle busy window.
- R8: Words presented while busy_o is high are dropped. They give no rd_valid_o and change no register.
- R9: master_mode_o is 0 during reset and during the busy window. At the edge that ends the window it takes the level din_level had in the window's last cycle, and it keeps that value until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_level | input | 1 | Data pin level, sampled as the mode select |
| word_i | input | 16 | Control word: direction, address, data |
| word_valid_i | input | 1 | Strobe for word_i |
| rd_data_o | output | 10 | Read result, zero when not valid |
| rd_valid_o | output | 1 | Read result valid, one cycle per read |
| busy_o | output | 1 | Reset sequence in progress |
| master_mode_o | output | 1 | Latched mode select (1 = master) |
| cfg_o | output | 70 | Contents of all seven registers, register i at bits [10*i+9:10*i] |

## Verification
The hardest case to reach from the ports is the mode latch. Its timing can only be seen if din_level changes exactly at the edges of the last busy cycle. The stimulus counts edges from reset release. It holds the pin at the opposite level for the whole window, switches it only in the final cycle, and switches it back right after. The check therefore passes only if the sample is taken on that single cycle. Words are also injected in the middle of the window to show that they are dropped, and a second reset with the other pin level shows that the mode is held and then re-latched.

// File: rtl/ctlword_pkg.sv
package ctlword_pkg;

  localparam int WORD_W = 16;
  localparam int CFG_W  = 10;
  localparam int ADDR_W = 5;

  // Field order is fixed by the host protocol: direction at the MSB.
  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [CFG_W-1:0]  data;
  } ctl_word_t;

  function automatic logic [CFG_W-1:0] cfg_default(int unsigned idx);
    logic [31:0] v;
    v = idx * 32'h0A5 + 32'h011;
    return v[CFG_W-1:0];
  endfunction

endpackage

// File: rtl/ctlword_rst_seq.sv
module ctlword_rst_seq #(
  parameter int BUSY_CYCLES = 3072,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_level,
  output logic rst_int_n,
  output logic busy_o,
  output logic mode_o
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   busy_q, busy_d;
  logic                   mode_q, mode_d;

  // Reset asserts at once and is released through a short flop chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_int_n = sync_q[SYNC_STAGES-1];

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    mode_d = mode_q;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        mode_d = din_level;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
      mode_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      mode_q <= mode_d;
    end
  end

  assign busy_o = busy_q;
  assign mode_o = mode_q;

endmodule

// File: rtl/ctlword_decode.sv
module ctlword_decode
  import ctlword_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int RO_IDX   = 5
) (
  input  logic [WORD_W-1:0]   word_i,
  input  logic                word_valid_i,
  input  logic                busy_i,
  output logic [NUM_REGS-1:0] wr_en_o,
  output logic [CFG_W-1:0]    wr_data_o,
  output logic                rd_req_o,
  output logic                rd_in_range_o,
  output logic [ADDR_W-1:0]   rd_idx_o
);

  ctl_word_t w;
  logic      accept;

  assign w      = ctl_word_t'(word_i);
  assign accept = word_valid_i & ~busy_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wen
    if (g == RO_IDX) begin : g_ro
      assign wr_en_o[g] = 1'b0;
    end else begin : g_rw
      assign wr_en_o[g] = accept & w.wr & (w.addr == ADDR_W'(g));
    end
  end

  assign wr_data_o     = w.data;
  assign rd_req_o      = accept & ~w.wr;
  assign rd_in_range_o = (w.addr < ADDR_W'(NUM_REGS));
  assign rd_idx_o      = w.addr;

endmodule

// File: rtl/ctlword_store.sv
module ctlword_store
  import ctlword_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int RO_IDX   = 5
) (
  input  logic                      clk,
  input  logic                      rst_int_n,
  input  logic [NUM_REGS-1:0]       wr_en_i,
  input  logic [CFG_W-1:0]          wr_data_i,
  output logic [NUM_REGS*CFG_W-1:0] cfg_o
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == RO_IDX) begin : g_ro
      // Fixed value; wr_en_i[g] is tied low by the decoder.
      assign cfg_o[g*CFG_W +: CFG_W] = cfg_default(g);
    end else begin : g_rw
      logic [CFG_W-1:0] val_q, val_d;

      always_comb begin
        val_d = val_q;
        if (wr_en_i[g]) val_d = wr_data_i;
      end

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) val_q <= cfg_default(g);
        else            val_q <= val_d;
      end

      assign cfg_o[g*CFG_W +: CFG_W] = val_q;
    end
  end

endmodule

// File: rtl/ctlword_regbank.sv
module ctlword_regbank
  import ctlword_pkg::*;
#(
  parameter int NUM_REGS    = 7,
  parameter int RO_IDX      = 5,
  parameter int BUSY_CYCLES = 3072,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      din_level,
  input  logic [WORD_W-1:0]         word_i,
  input  logic                      word_valid_i,
  output logic [CFG_W-1:0]          rd_data_o,
  output logic                      rd_valid_o,
  output logic                      busy_o,
  output logic                      master_mode_o,
  output logic [NUM_REGS*CFG_W-1:0] cfg_o
);

  logic                rst_int_n;
  logic                busy;
  logic [NUM_REGS-1:0] wr_en;
  logic [CFG_W-1:0]    wr_data;
  logic                rd_req, rd_in_range;
  logic [ADDR_W-1:0]   rd_idx;
  logic [CFG_W-1:0]    rd_sel;
  logic [CFG_W-1:0]    rd_data_q, rd_data_d;
  logic                rd_valid_q, rd_valid_d;

  ctlword_rst_seq #(
    .BUSY_CYCLES(BUSY_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .din_level(din_level),
    .rst_int_n(rst_int_n),
    .busy_o   (busy),
    .mode_o   (master_mode_o)
  );

  ctlword_decode #(
    .NUM_REGS(NUM_REGS),
    .RO_IDX  (RO_IDX)
  ) dec_i (
    .word_i       (word_i),
    .word_valid_i (word_valid_i),
    .busy_i       (busy),
    .wr_en_o      (wr_en),
    .wr_data_o    (wr_data),
    .rd_req_o     (rd_req),
    .rd_in_range_o(rd_in_range),
    .rd_idx_o     (rd_idx)
  );

  ctlword_store #(
    .NUM_REGS(NUM_REGS),
    .RO_IDX  (RO_IDX)
  ) store_i (
    .clk      (clk),
    .rst_int_n(rst_int_n),
    .wr_en_i  (wr_en),
    .wr_data_i(wr_data),
    .cfg_o    (cfg_o)
  );

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == ADDR_W'(i)) rd_sel = cfg_o[i*CFG_W +: CFG_W];
    end
  end

  always_comb begin
    rd_valid_d = rd_req;
    rd_data_d  = (rd_req && rd_in_range) ? rd_sel : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_valid_d;
      rd_data_q  <= rd_data_d;
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign busy_o     = busy;

endmodule

// File: rtl/ctlword_regbank_chk.sv
module ctlword_regbank_chk
  import ctlword_pkg::*;
#(
  parameter int NUM_REGS    = 7,
  parameter int RO_IDX      = 5,
  parameter int BUSY_CYCLES = 3072,
  parameter int SYNC_STAGES = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [WORD_W-1:0]         word_i,
  input logic                      word_valid_i,
  input logic [CFG_W-1:0]          rd_data_o,
  input logic                      rd_valid_o,
  input logic                      busy_o,
  input logic                      master_mode_o,
  input logic [NUM_REGS*CFG_W-1:0] cfg_o
);

  logic        acc_read;
  logic [31:0] busy_cnt;

  assign acc_read = word_valid_i && !busy_o && !word_i[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
  end

  p_read_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_read |=> rd_valid_o);

  p_no_spurious_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_read |=> !rd_valid_o);

  p_idle_data_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> (rd_data_o == '0));

  p_ro_unchanged_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_i && word_i[15] && word_i[14:10] == ADDR_W'(RO_IDX))
    |=> $stable(cfg_o[RO_IDX*CFG_W +: CFG_W]));

  p_oor_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_read && word_i[14:10] >= ADDR_W'(NUM_REGS)) |=> (rd_data_o == '0));

  p_oor_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_i && word_i[15] && word_i[14:10] >= ADDR_W'(NUM_REGS))
    |=> $stable(cfg_o));

  p_busy_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_cnt == 32'(BUSY_CYCLES + SYNC_STAGES)));

  p_busy_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(cfg_o));

  p_mode_low_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !master_mode_o);

  p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(master_mode_o));

endmodule

bind ctlword_regbank ctlword_regbank_chk #(
  .NUM_REGS   (NUM_REGS),
  .RO_IDX     (RO_IDX),
  .BUSY_CYCLES(BUSY_CYCLES),
  .SYNC_STAGES(SYNC_STAGES)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .word_i       (word_i),
  .word_valid_i (word_valid_i),
  .rd_data_o    (rd_data_o),
  .rd_valid_o   (rd_valid_o),
  .busy_o       (busy_o),
  .master_mode_o(master_mode_o),
  .cfg_o        (cfg_o)
);

// File: tb/ctlword_regbank_tb_top.sv
`timescale 1ns/1ps
module ctlword_regbank_tb_top;

  localparam int NREG = 7;
  localparam int DW   = 10;
  localparam int RO   = 5;
  localparam int BUSY = 3072;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             din_level;
  logic [15:0]      word_i;
  logic             word_valid_i;
  logic [DW-1:0]    rd_data_o;
  logic             rd_valid_o;
  logic             busy_o;
  logic             master_mode_o;
  logic [NREG*DW-1:0] cfg_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [DW-1:0] model [NREG];

  always #2.5 clk = ~clk;

  ctlword_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .din_level(din_level),
    .word_i(word_i), .word_valid_i(word_valid_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .busy_o(busy_o), .master_mode_o(master_mode_o), .cfg_o(cfg_o)
  );

  function automatic logic [DW-1:0] dflt(int i);
    return DW'((i * 'h0A5 + 'h011) & 'h3FF);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_cfg(string req);
    for (int i = 0; i < NREG; i++)
      chk(cfg_o[i*DW +: DW] == model[i], req, $sformatf("cfg reg %0d", i),
          32'(cfg_o[i*DW +: DW]), 32'(model[i]));
  endtask

  // Reset, then run the busy window with the mode pin at the target level
  // only in the last cycle of the window.
  task automatic do_reset(bit mode_val);
    @(negedge clk);
    rst_n = 1'b0; word_valid_i = 1'b0; din_level = ~mode_val;
    for (int i = 0; i < NREG; i++) model[i] = dflt(i);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b1, "R7", "busy in reset", 32'(busy_o), 1);
    chk(master_mode_o == 1'b0, "R9", "mode in reset", 32'(master_mode_o), 0);
    check_cfg("R1");
    rst_n = 1'b1;
    for (int j = 1; j <= BUSY + 2; j++) begin
      @(negedge clk);
      if (j == 100) begin
        word_i = 16'h0000; word_valid_i = 1'b1;             // read reg 0
      end else if (j == 101) begin
        chk(rd_valid_o == 1'b0, "R8", "read dropped while busy", 32'(rd_valid_o), 0);
        word_i = {1'b1, 5'd1, 10'h2AA};                       // write reg 1
      end else if (j == 102) begin
        word_valid_i = 1'b0;
      end else if (j == 103) begin
        check_cfg("R8");
        chk(master_mode_o == 1'b0, "R9", "mode while busy", 32'(master_mode_o), 0);
      end
      if (j == BUSY + 1) begin
        chk(busy_o == 1'b1, "R7", "busy in last window cycle", 32'(busy_o), 1);
        din_level = mode_val;
      end
      if (j == BUSY + 2) begin
        chk(busy_o == 1'b0, "R7", "busy after window", 32'(busy_o), 0);
        chk(master_mode_o == mode_val, "R9", "latched mode", 32'(master_mode_o), 32'(mode_val));
        din_level = ~mode_val;
      end
    end
  endtask

  // Present one word (or an idle cycle) and check the outcome one edge later.
  task automatic send(bit vld, logic [15:0] w);
    bit          is_rd;
    int          a;
    logic [DW-1:0] exp_d;
    string       req;
    word_i = w; word_valid_i = vld;
    is_rd = vld && !w[15];
    a     = int'(w[14:10]);
    exp_d = (is_rd && a < NREG) ? model[a] : '0;
    if (vld && w[15] && a < NREG && a != RO) model[a] = w[9:0];
    @(negedge clk);
    if (!vld)            req = "R4";
    else if (a >= NREG)  req = "R6";
    else if (a == RO)    req = "R5";
    else if (w[15])      req = "R2";
    else                 req = "R3";
    chk(rd_valid_o == is_rd, is_rd ? req : "R4", "rd_valid", 32'(rd_valid_o), 32'(is_rd));
    chk(rd_data_o == exp_d, is_rd ? req : "R4", "rd_data", 32'(rd_data_o), 32'(exp_d));
    check_cfg(req);
  endtask

  initial begin
    logic [15:0] w;
    bit          v;
    void'($urandom(32'h5EED_0123));
    rst_n = 1'b0; din_level = 1'b0; word_i = '0; word_valid_i = 1'b0;

    do_reset(1'b1);
    chk(master_mode_o == 1'b1, "R9", "mode held", 32'(master_mode_o), 1);

    // Directed corner cases
    send(1'b1, {1'b1, 5'd0, 10'h3FF});           // R2 write reg 0
    send(1'b1, {1'b1, 5'd6, 10'h155});           // R2 highest writable
    send(1'b1, {1'b0, 5'd6, 10'h0F0});           // R3 read with nonzero data field
    send(1'b1, {1'b1, 5'd5, 10'h000});           // R5 write to read-only
    send(1'b1, {1'b0, 5'd5, 10'h000});           // R5 read back default
    send(1'b1, {1'b1, 5'd7, 10'h123});           // R6 write first out-of-range
    send(1'b1, {1'b1, 5'd31, 10'h321});          // R6 write top address
    send(1'b1, {1'b0, 5'd31, 10'h000});          // R6 read top address
    send(1'b0, 16'hFFFF);                        // R4 idle
    for (int i = 0; i < NREG; i++) send(1'b1, {1'b0, 5'(i), 10'h0}); // R3 all

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      v = ($urandom % 4) != 0;
      w[15]    = $urandom % 2;
      w[14:10] = ($urandom % 8 == 0) ? 5'($urandom % 32) : 5'($urandom % 8);
      w[9:0]   = 10'($urandom);
      send(v, w);
    end

    // Second reset: mode re-latched to 0, defaults restored (R1, R9)
    do_reset(1'b0);
    check_cfg("R1");
    for (int n = 0; n < 200; n++) begin
      chk(master_mode_o == 1'b0, "R9", "mode held after relatch", 32'(master_mode_o), 0);
      send(1'b1, {1'($urandom % 2), 5'($urandom % 8), 10'($urandom)});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule